// File: doc/BRIEF.md
# Asymmetric Dual-Slope Quench Timer

This block is a clocked, digital stand-in for the analog timer that paces a quenched oscillator. The timer toggles between a sample phase, in which oscillation is allowed, and a quench phase. An internal level register takes the place of a capacitor voltage. It moves down by a discharge step while the control input is high and up by a smaller charge step while the control input is low. It moves only on cycles that carry a tick-enable pulse. A two-threshold comparator with hysteresis turns the level into a single timer bit, and an external controller reads that bit back.

The level is kept in fixed point with 4 fractional bits. Full scale is 12 units (192 LSB), the upper threshold is 9 units (144 LSB) and the lower threshold is 3 units (48 LSB). A clear preloads full scale and puts the timer in the sample phase. From there a discharge run of 36 ticks reaches the lower threshold and enters quench. A charge run of 32 ticks then brings the level back to the upper threshold. The two phase lengths therefore follow from the threshold spacing and the step ratio, and no terminal count sets them.

The comparator is a two-state machine. In the SAMPLE state the output is 0. The transition SAMPLE to QUENCH is taken when the next level is at or below the lower threshold. In the QUENCH state the output is 1. The transition QUENCH to SAMPLE is taken when the next level is at or above the upper threshold. A clear forces SAMPLE from either state. The phase register and the level register are written on the same clock edge, so the timer bit and the level always agree.

Top module: `quench_timer_dual`

## Requirements
- R1: A cycle with clr_i high sets level_o to 192 (12.0 units) and timer_o to 0 (sample phase), both visible after that clock edge.
- R2: With clr_i low, tick_i high and ctrl_i high, the level drops by 4 LSB at the clock edge.
- R3: With clr_i low, tick_i high and ctrl_i low, the level rises by 3 LSB at the clock edge.
- R4: With clr_i low and tick_i low, ctrl_i is ignored and level_o and timer_o keep their values.
- R5: In the sample phase, timer_o goes to 1 on the same edge at which the level becomes at or below 48 LSB.
- R6: While the level lies strictly between 48 and 144 LSB, timer_o keeps its previous value.
- R7: In the quench phase, timer_o goes to 0 on the same edge at which the level becomes at or above 144 LSB.
- R8: A discharge step that would go below zero leaves the level at 0.
- R9: A charge step that would exceed full scale leaves the level at 192.
- R10: clr_i takes priority over ctrl_i and tick_i in the same cycle, from either phase.
- R11: After a clear, a run of discharge ticks needs exactly 36 ticks to enter quench, and a following run of charge ticks needs exactly 32 ticks to return to sample.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock; all state changes on its rising edge |
| clr_i | input | 1 | Synchronous clear: preload full scale and enter sample phase |
| ctrl_i | input | 1 | Slope select: 1 discharges the level, 0 charges it |
| tick_i | input | 1 | Step enable; the level moves only on cycles where this is 1 |
| timer_o | output | 1 | Timer bit: 0 in sample phase, 1 in quench phase |
| level_o | output | 8 | Current level, unsigned fixed point with 4 fractional bits |

## Verification
A wrong step size or a missing saturation shows on level_o at the edge right after the offending tick, and every later value then differs from the expected one. A phase register that switches at the wrong threshold, or that fails to hold between thresholds, shows on timer_o at the exact edge where the level crosses 48 or 144 LSB. It also shifts the 36-tick and 32-tick phase lengths. A clear that loses to the control inputs shows in the first cycle after the clear as a level other than 192.

// File: rtl/qtmr_pkg.sv
package qtmr_pkg;

    // Phase of the hysteresis comparator; the encoding is the timer bit.
    typedef enum logic [0:0] {
        PH_SAMPLE = 1'b0,
        PH_QUENCH = 1'b1
    } phase_t;

    // What the level register does in a cycle.
    typedef enum logic [1:0] {
        MV_PRELOAD = 2'd0,
        MV_HOLD    = 2'd1,
        MV_DOWN    = 2'd2,
        MV_UP      = 2'd3
    } move_t;

endpackage

// File: rtl/qtmr_level.sv
module qtmr_level
    import qtmr_pkg::*;
#(
    parameter int LW      = 8,
    parameter int FULL    = 192,
    parameter int DN_STEP = 4,
    parameter int UP_STEP = 3
) (
    input  logic          clk_i,
    input  logic          clr_i,
    input  logic          ctrl_i,
    input  logic          tick_i,
    output logic [LW-1:0] lvl_q_o,
    output logic [LW-1:0] lvl_nxt_o
);

    localparam int EW = LW + 1;
    localparam logic [EW-1:0] FULL_X = EW'(FULL);
    localparam logic [EW-1:0] DN_X   = EW'(DN_STEP);
    localparam logic [EW-1:0] UP_X   = EW'(UP_STEP);

    move_t         move;
    logic [EW-1:0] cur_x;
    logic [EW-1:0] up_sum;
    logic [EW-1:0] dn_dif;

    // Select the action; clear wins over everything else.
    always_comb begin
        if (clr_i)        move = MV_PRELOAD;
        else if (!tick_i) move = MV_HOLD;
        else if (ctrl_i)  move = MV_DOWN;
        else              move = MV_UP;
    end

    always_comb begin
        cur_x  = {1'b0, lvl_q_o};
        up_sum = cur_x + UP_X;
        dn_dif = cur_x - DN_X;
        unique case (move)
            MV_PRELOAD: lvl_nxt_o = LW'(FULL);
            MV_HOLD:    lvl_nxt_o = lvl_q_o;
            MV_DOWN:    lvl_nxt_o = (cur_x < DN_X) ? '0 : dn_dif[LW-1:0];
            MV_UP:      lvl_nxt_o = (up_sum > FULL_X) ? LW'(FULL) : up_sum[LW-1:0];
            default:    lvl_nxt_o = lvl_q_o;
        endcase
    end

    always_ff @(posedge clk_i) begin
        lvl_q_o <= lvl_nxt_o;
    end

    // R2
    dn_step_chk: assert property (@(posedge clk_i) disable iff (clr_i)
        (tick_i && ctrl_i && lvl_q_o >= LW'(DN_STEP))
        |=> (lvl_q_o == $past(lvl_q_o) - LW'(DN_STEP)));

    // R3
    up_step_chk: assert property (@(posedge clk_i) disable iff (clr_i)
        (tick_i && !ctrl_i && lvl_q_o <= LW'(FULL - UP_STEP))
        |=> (lvl_q_o == $past(lvl_q_o) + LW'(UP_STEP)));

    // R4
    idle_hold_chk: assert property (@(posedge clk_i) disable iff (clr_i)
        (!tick_i) |=> $stable(lvl_q_o));

    // R8
    floor_sat_chk: assert property (@(posedge clk_i) disable iff (clr_i)
        (tick_i && ctrl_i && lvl_q_o < LW'(DN_STEP)) |=> (lvl_q_o == '0));

    // R9
    ceil_sat_chk: assert property (@(posedge clk_i) disable iff (clr_i)
        (tick_i && !ctrl_i && lvl_q_o > LW'(FULL - UP_STEP)) |=> (lvl_q_o == LW'(FULL)));

endmodule

// File: rtl/qtmr_hyst.sv
module qtmr_hyst
    import qtmr_pkg::*;
#(
    parameter int LW    = 8,
    parameter int HI_LV = 144,
    parameter int LO_LV = 48
) (
    input  logic          clk_i,
    input  logic          clr_i,
    input  logic [LW-1:0] lvl_nxt_i,
    output logic          timer_o
);

    phase_t ph_q;
    phase_t ph_d;

    // Next-phase logic with hysteresis between the two thresholds.
    always_comb begin
        ph_d = ph_q;
        if (clr_i) begin
            ph_d = PH_SAMPLE;
        end else begin
            unique case (ph_q)
                PH_SAMPLE: if (lvl_nxt_i <= LW'(LO_LV)) ph_d = PH_QUENCH;
                PH_QUENCH: if (lvl_nxt_i >= LW'(HI_LV)) ph_d = PH_SAMPLE;
                default:   ph_d = PH_SAMPLE;
            endcase
        end
    end

    // State register.
    always_ff @(posedge clk_i) begin
        ph_q <= ph_d;
    end

    // Output decode.
    always_comb begin
        timer_o = (ph_q == PH_QUENCH);
    end

endmodule

// File: rtl/quench_timer_dual.sv
module quench_timer_dual
    import qtmr_pkg::*;
#(
    parameter int FRAC_BITS  = 4,
    parameter int FULL_UNITS = 12,
    parameter int HI_UNITS   = 9,
    parameter int LO_UNITS   = 3,
    parameter int DN_STEP    = 4,
    parameter int UP_STEP    = 3
) (
    input  logic                                           clk_i,
    input  logic                                           clr_i,
    input  logic                                           ctrl_i,
    input  logic                                           tick_i,
    output logic                                           timer_o,
    output logic [$clog2(FULL_UNITS+1)+FRAC_BITS-1:0]      level_o
);

    localparam int LW    = $clog2(FULL_UNITS + 1) + FRAC_BITS;
    localparam int FULL  = FULL_UNITS << FRAC_BITS;
    localparam int HI_LV = HI_UNITS << FRAC_BITS;
    localparam int LO_LV = LO_UNITS << FRAC_BITS;

    logic [LW-1:0] lvl_nxt;

    qtmr_level #(
        .LW(LW), .FULL(FULL), .DN_STEP(DN_STEP), .UP_STEP(UP_STEP)
    ) u_level (
        .clk_i     (clk_i),
        .clr_i     (clr_i),
        .ctrl_i    (ctrl_i),
        .tick_i    (tick_i),
        .lvl_q_o   (level_o),
        .lvl_nxt_o (lvl_nxt)
    );

    qtmr_hyst #(
        .LW(LW), .HI_LV(HI_LV), .LO_LV(LO_LV)
    ) u_hyst (
        .clk_i     (clk_i),
        .clr_i     (clr_i),
        .lvl_nxt_i (lvl_nxt),
        .timer_o   (timer_o)
    );

    // R5
    rise_thresh_chk: assert property (@(posedge clk_i) disable iff (clr_i)
        $rose(timer_o) |-> (level_o <= LW'(LO_LV)));

    // R7
    fall_thresh_chk: assert property (@(posedge clk_i) disable iff (clr_i)
        $fell(timer_o) |-> (level_o >= LW'(HI_LV)));

    // R6
    mid_hold_chk: assert property (@(posedge clk_i) disable iff (clr_i)
        (level_o > LW'(LO_LV) && level_o < LW'(HI_LV)) |-> $stable(timer_o));

endmodule

// File: tb/sim_quench_timer_dual.sv
module sim_quench_timer_dual;

    localparam int FULL = 192;
    localparam int HI   = 144;
    localparam int LO   = 48;
    localparam int DN   = 4;
    localparam int UP   = 3;

    typedef struct {
        int    lvl;
        bit    tmr;
        string tag;
    } exp_t;

    logic       clk = 1'b0;
    logic       clr = 1'b1;
    logic       ctrl = 1'b0;
    logic       b_tick = 1'b0;
    logic       timer_o;
    logic [7:0] level_o;

    exp_t q[$];
    int   n_chk  = 0;
    int   n_fail = 0;
    int   m_lvl  = FULL;
    bit   m_tmr  = 1'b0;
    bit   done   = 1'b0;

    always #2 clk = ~clk;

    quench_timer_dual u0 (
        .clk_i   (clk),
        .clr_i   (clr),
        .ctrl_i  (ctrl),
        .tick_i  (b_tick),
        .timer_o (timer_o),
        .level_o (level_o)
    );

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    // Driver: apply one cycle of inputs and push the expected result.
    task automatic drive(input bit c, input bit k, input bit t, input string tag);
        exp_t e;
        @(negedge clk);
        clr = c; ctrl = k; b_tick = t;
        if (c) begin
            m_lvl = FULL; m_tmr = 1'b0;
        end else if (t) begin
            if (k) m_lvl = (m_lvl < DN) ? 0 : m_lvl - DN;
            else   m_lvl = (m_lvl + UP > FULL) ? FULL : m_lvl + UP;
            if (!m_tmr && m_lvl <= LO)     m_tmr = 1'b1;
            else if (m_tmr && m_lvl >= HI) m_tmr = 1'b0;
        end
        e.lvl = m_lvl; e.tmr = m_tmr; e.tag = tag;
        q.push_back(e);
    endtask

    task automatic check_val(input string tag, input int got, input int exp);
        n_chk++;
        if (got != exp) begin
            n_fail++;
            $display("FAIL %s got %0d expected %0d", tag, got, exp);
        end
    endtask

    // Monitor: compare each result just after the edge that produced it.
    always @(posedge clk) begin
        #1;
        if (q.size() > 0) begin
            exp_t e;
            e = q.pop_front();
            n_chk++;
            if (int'(level_o) != e.lvl || timer_o != e.tmr) begin
                n_fail++;
                $display("FAIL %s level got %0d expected %0d, timer got %0d expected %0d",
                         e.tag, level_o, e.lvl, timer_o, e.tmr);
            end
        end
    end

    initial begin
        #(200000 * 4);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        int cnt;
        // R1 clear / reset state
        drive(1, 0, 0, "R1");
        drive(1, 1, 0, "R1");
        // R4 no tick: control ignored
        repeat (3) drive(0, 1, 0, "R4");
        // R2 discharge steps
        repeat (5) drive(0, 1, 1, "R2");
        // R3 charge steps
        repeat (3) drive(0, 0, 1, "R3");
        repeat (2) drive(0, 0, 0, "R4");
        // R9 saturate at full scale from 181
        repeat (6) drive(0, 0, 1, "R9");
        // R5 discharge down through lower threshold
        repeat (40) drive(0, 1, 1, "R5");
        // R4 idle while in quench
        repeat (2) drive(0, 0, 0, "R4");
        // R6 charge between thresholds, timer stays high
        repeat (10) drive(0, 0, 1, "R6");
        // R7 charge until upper threshold is crossed
        repeat (28) drive(0, 0, 1, "R7");
        // R6 discharge between thresholds, timer stays low
        repeat (5) drive(0, 1, 1, "R6");
        // R10 clear beats tick and control
        drive(1, 1, 1, "R10");
        repeat (36) drive(0, 1, 1, "R5");
        drive(1, 0, 1, "R10");
        // R8 saturate at zero
        repeat (50) drive(0, 1, 1, "R8");
        drive(0, 0, 1, "R8");
        drive(0, 1, 1, "R8");
        // R11 phase lengths
        drive(1, 0, 0, "R11");
        cnt = 0;
        for (int i = 0; i < 60; i++) begin
            drive(0, 1, 1, "R11");
            cnt++;
            @(posedge clk); #1;
            if (timer_o) break;
        end
        check_val("R11 discharge ticks", cnt, (FULL - LO) / DN);
        cnt = 0;
        for (int i = 0; i < 60; i++) begin
            drive(0, 0, 1, "R11");
            cnt++;
            @(posedge clk); #1;
            if (!timer_o) break;
        end
        check_val("R11 charge ticks", cnt, (HI - LO + UP - 1) / UP);
        repeat (3) @(posedge clk);
        #2;
        check_val("queue drained", q.size(), 0);
        finish_run();
    end

endmodule